// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the front end of a synthesizable NAND flash device model. It watches an 8-bit data bus and, on every write strobe taken while the chip is selected, classifies the byte. With the command latch enable high, the byte is a command. With the address latch enable high, it is an address byte. Otherwise the byte is passed over, because page data is handled elsewhere. The block keeps the current command, a little-endian multi-byte address, an address-cycle count and a column offset.

From that state it raises single-cycle action pulses for a storage engine: load a page, open a program buffer, commit a program, erase a block, return the identifier and return status. Some commands act as soon as they arrive. Others wait for a specific address cycle, and that cycle depends on page geometry and device size, both chosen by parameters. The read variants inherited from older small-page parts rewrite the column offset. The large-page read confirm and random-column commands go around the normal command path.

Top module: `nand_cmd_seq`

## Requirements
- R1: After rst_ni is asserted, the command is 0x00 and address, cycle count and column offset are zero. All action pulses are low and the bad-command flag is clear.
- R2: A strobe with ce_ni low and cle_i high stores the byte as the current command. The codes 0x01 and 0x50 are stored as 0x00.
- R3: Command 0x00 sets the column offset to 0, 0x01 sets it to 0x100 and 0x50 sets it to PAGE_BYTES. Every other stored command leaves the offset unchanged.
- R4: Address byte number n (counting from 0) is written to address bits 8n+7:8n while n is below ADDR_BYTES. Bytes past the last slot change nothing in the address.
- R5: Each address byte increments the cycle count, which saturates at 7. Every stored command clears the count except 0xE0, which leaves it unchanged.
- R6: For current command 0x90, the first address byte raises the identifier pulse. The address byte that brings the count to the trigger count raises the load pulse under command 0x00 and the program-setup pulse under 0x80. The trigger count is 3 for small pages, 4 for large pages on devices of at most 1024 Mbit, and 5 for larger devices.
- R7: Some pulses fire on the command strobe itself. 0x70 raises status, 0x10 raises program and 0xD0 raises erase. In large-page mode, 0xE0 and 0x35 raise load. Each pulse is high for exactly the one cycle after the strobe edge, and at most one pulse is high at a time.
- R8: On 0xD0, the address is shifted left by 16 bits in large-page mode and by 8 bits in small-page mode, keeping the low 8*ADDR_BYTES bits.
- R9: Command 0xFF stores command 0x00 and clears the address, cycle count and column offset.
- R10: In large-page mode, 0x30 arriving while the command is 0x00 changes nothing. Also in large-page mode, 0x05 clears address bits 15:0 and the cycle count and keeps the command. In small-page mode, both codes are stored as ordinary commands that raise no pulse.
- R11: A command byte outside the fifteen defined codes is stored and raises no pulse. It sets a bad-command flag that only rst_ni clears.
- R12: Strobes with ce_ni high, and cycles with we_i low, change no state. When cle_i and ale_i are both high, the byte is treated as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_i | input | 1 | Write strobe, one cycle per bus byte |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| io_i | input | 8 | Bus byte |
| cmd_o | output | 8 | Current command |
| addr_o | output | 8*ADDR_BYTES | Assembled address |
| addr_cnt_o | output | 3 | Address cycle count |
| col_off_o | output | OFF_W | Column offset |
| act_load_o | output | 1 | Load page pulse |
| act_setup_o | output | 1 | Program buffer setup pulse |
| act_prog_o | output | 1 | Program commit pulse |
| act_erase_o | output | 1 | Block erase pulse |
| act_id_o | output | 1 | Identifier read pulse |
| act_status_o | output | 1 | Status read pulse |
| bad_cmd_o | output | 1 | Sticky unknown-command flag |

## Verification
The bench builds three copies of the block and drives all three with the same stimulus. The first is large-page at 2048 Mbit, where the read trigger falls on the fifth address byte. The second is large-page at 1024 Mbit, where it falls on the fourth. The third is small-page with 512-byte pages, where it falls on the third, the erase shift is 8 bits, and 0x30, 0x05, 0xE0 and 0x35 behave as plain commands. With this setup, one byte sequence shows each trigger point, each erase shift and each PAGE_BYTES offset side by side, compared against a per-configuration behavioural model.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_READ_HI   = 8'h01;
  localparam logic [7:0] OP_READ_SPR  = 8'h50;
  localparam logic [7:0] OP_RD_CONF   = 8'h30;
  localparam logic [7:0] OP_RND_START = 8'h05;
  localparam logic [7:0] OP_RND_CONF  = 8'hE0;
  localparam logic [7:0] OP_RD_DIRECT = 8'h35;
  localparam logic [7:0] OP_ID        = 8'h90;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_PRG_START = 8'h80;
  localparam logic [7:0] OP_PRG_CONF  = 8'h10;
  localparam logic [7:0] OP_ERS_START = 8'h60;
  localparam logic [7:0] OP_ERS_CONF  = 8'hD0;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_COPYBACK  = 8'h85;

  typedef enum logic [1:0] {OFF_KEEP, OFF_ZERO, OFF_HALF, OFF_PAGE} off_sel_e;

  typedef struct packed {
    logic load;
    logic setup;
    logic prog;
    logic erase;
    logic id;
    logic status;
  } act_t;
endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1
) (
  input  logic [7:0] byte_i,
  input  logic [7:0] cur_cmd_i,
  output logic       skip_o,
  output logic       rnd_start_o,
  output logic [7:0] cmd_next_o,
  output off_sel_e   off_sel_o,
  output logic       known_o,
  output logic       reset_o,
  output logic       keep_cnt_o,
  output act_t       imm_act_o
);
  always_comb begin
    skip_o      = LARGE_PAGE && (cur_cmd_i == OP_READ) && (byte_i == OP_RD_CONF);
    rnd_start_o = LARGE_PAGE && (byte_i == OP_RND_START);
    reset_o     = (byte_i == OP_RESET);
    keep_cnt_o  = (byte_i == OP_RND_CONF);

    cmd_next_o = byte_i;
    off_sel_o  = OFF_KEEP;
    unique case (byte_i)
      OP_READ:     off_sel_o = OFF_ZERO;
      OP_READ_HI:  begin off_sel_o = OFF_HALF; cmd_next_o = OP_READ; end
      OP_READ_SPR: begin off_sel_o = OFF_PAGE; cmd_next_o = OP_READ; end
      default:     ;
    endcase

    known_o = byte_i inside {OP_READ, OP_READ_HI, OP_READ_SPR, OP_RD_CONF,
                             OP_RND_START, OP_RND_CONF, OP_RD_DIRECT, OP_ID,
                             OP_RESET, OP_PRG_START, OP_PRG_CONF, OP_ERS_START,
                             OP_ERS_CONF, OP_STATUS, OP_COPYBACK};

    imm_act_o        = '0;
    imm_act_o.status = (byte_i == OP_STATUS);
    imm_act_o.prog   = (byte_i == OP_PRG_CONF);
    imm_act_o.erase  = (byte_i == OP_ERS_CONF);
    imm_act_o.load   = LARGE_PAGE && ((byte_i == OP_RND_CONF) || (byte_i == OP_RD_DIRECT));
  end
endmodule

// File: rtl/nand_addr_unit.sv
module nand_addr_unit #(
  parameter int ADDR_BYTES = 5,
  parameter int COL_BITS   = 16,
  parameter int ERASE_SH   = 16,
  parameter int CNT_W      = 3,
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              clr_col_i,
  input  logic              clr_cnt_i,
  input  logic              shift_i,
  input  logic              wr_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_all_i) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (wr_i) begin
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (cnt_q == CNT_W'(b)) addr_q[8*b +: 8] <= byte_i;
      end
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end else begin
      if (clr_col_i) addr_q[COL_BITS-1:0] <= '0;
      else if (shift_i) addr_q <= addr_q << ERASE_SH;
      if (clr_cnt_i || clr_col_i) cnt_q <= '0;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  // R5: an address byte advances the count by one unless saturated
  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_all_i) |=> ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || ($past(cnt_q) == '1)));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter int DEV_MBIT   = 2048,
  parameter int PAGE_BYTES = 2048,
  parameter int ADDR_BYTES = 5,
  parameter int OFF_W      = 16,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int CNT_W     = 3,
  localparam int COL_BITS  = LARGE_PAGE ? 16 : 8,
  localparam int TRIG_CNT  = !LARGE_PAGE ? 3 : ((DEV_MBIT <= 1024) ? 4 : 5)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_i,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic [7:0]        io_i,
  output logic [7:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  addr_cnt_o,
  output logic [OFF_W-1:0]  col_off_o,
  output logic              act_load_o,
  output logic              act_setup_o,
  output logic              act_prog_o,
  output logic              act_erase_o,
  output logic              act_id_o,
  output logic              act_status_o,
  output logic              bad_cmd_o
);
  logic       wr_fire, cmd_fire, adr_fire, cmd_take;
  logic       dec_skip, dec_rnd, dec_known, dec_reset, dec_keep;
  logic [7:0] dec_cmd;
  off_sel_e   dec_off;
  act_t       dec_act, adr_act, act_q;

  logic [7:0]       cmd_q;
  logic [OFF_W-1:0] off_q;
  logic             bad_q;
  logic [CNT_W-1:0] cnt;

  assign wr_fire  = we_i && !ce_ni;
  assign cmd_fire = wr_fire && cle_i;
  assign adr_fire = wr_fire && !cle_i && ale_i;
  assign cmd_take = cmd_fire && !dec_skip && !dec_rnd;

  nand_op_decode #(.LARGE_PAGE(LARGE_PAGE)) u_dec (
    .byte_i      (io_i),
    .cur_cmd_i   (cmd_q),
    .skip_o      (dec_skip),
    .rnd_start_o (dec_rnd),
    .cmd_next_o  (dec_cmd),
    .off_sel_o   (dec_off),
    .known_o     (dec_known),
    .reset_o     (dec_reset),
    .keep_cnt_o  (dec_keep),
    .imm_act_o   (dec_act)
  );

  nand_addr_unit #(
    .ADDR_BYTES (ADDR_BYTES),
    .COL_BITS   (COL_BITS),
    .ERASE_SH   (COL_BITS),
    .CNT_W      (CNT_W)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (cmd_take && dec_reset),
    .clr_col_i (cmd_fire && dec_rnd),
    .clr_cnt_i (cmd_take && !dec_keep),
    .shift_i   (cmd_take && dec_act.erase),
    .wr_i      (adr_fire),
    .byte_i    (io_i),
    .addr_o    (addr_o),
    .cnt_o     (cnt)
  );

  // address-cycle triggered actions, evaluated on the count before the increment
  always_comb begin
    adr_act       = '0;
    adr_act.id    = (cmd_q == OP_ID) && (cnt == '0);
    adr_act.load  = (cmd_q == OP_READ) && (cnt == CNT_W'(TRIG_CNT - 1));
    adr_act.setup = (cmd_q == OP_PRG_START) && (cnt == CNT_W'(TRIG_CNT - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= OP_READ;
      off_q <= '0;
      bad_q <= 1'b0;
      act_q <= '0;
    end else begin
      act_q <= cmd_take ? dec_act : (adr_fire ? adr_act : '0);
      if (cmd_take) begin
        if (!dec_known) bad_q <= 1'b1;
        if (dec_reset) begin
          cmd_q <= OP_READ;
          off_q <= '0;
        end else begin
          cmd_q <= dec_cmd;
          unique case (dec_off)
            OFF_ZERO: off_q <= '0;
            OFF_HALF: off_q <= OFF_W'(256);
            OFF_PAGE: off_q <= OFF_W'(PAGE_BYTES);
            default:  ;
          endcase
        end
      end
    end
  end

  assign cmd_o        = cmd_q;
  assign addr_cnt_o   = cnt;
  assign col_off_o    = off_q;
  assign bad_cmd_o    = bad_q;
  assign act_load_o   = act_q.load;
  assign act_setup_o  = act_q.setup;
  assign act_prog_o   = act_q.prog;
  assign act_erase_o  = act_q.erase;
  assign act_id_o     = act_q.id;
  assign act_status_o = act_q.status;

  assert_one_action_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_q));
  assert_hold_cmd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_fire) |-> $stable(cmd_q));
  assert_bad_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bad_q) |-> bad_q);
  assert_erase_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.erase |-> (cmd_q == OP_ERS_CONF));
  assert_id_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.id |-> ((cmd_q == OP_ID) && (cnt == CNT_W'(1))));
endmodule

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we = 1'b0, cle = 1'b0, ale = 1'b0;
  logic [7:0] io = 8'h00;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  logic [7:0]  o_cmd  [3];
  logic [39:0] o_addr [3];
  logic [2:0]  o_cnt  [3];
  logic [15:0] o_off  [3];
  logic [5:0]  o_act  [3];
  logic        o_bad  [3];

  nand_cmd_seq #(.LARGE_PAGE(1'b1), .DEV_MBIT(2048), .PAGE_BYTES(2048)) u_nand_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_i(we), .cle_i(cle), .ale_i(ale), .io_i(io),
    .cmd_o(o_cmd[0]), .addr_o(o_addr[0]), .addr_cnt_o(o_cnt[0]), .col_off_o(o_off[0]),
    .act_load_o(o_act[0][5]), .act_setup_o(o_act[0][4]), .act_prog_o(o_act[0][3]),
    .act_erase_o(o_act[0][2]), .act_id_o(o_act[0][1]), .act_status_o(o_act[0][0]),
    .bad_cmd_o(o_bad[0]));

  nand_cmd_seq #(.LARGE_PAGE(1'b1), .DEV_MBIT(1024), .PAGE_BYTES(2048)) u_nand_cmd_seq_lp1g (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_i(we), .cle_i(cle), .ale_i(ale), .io_i(io),
    .cmd_o(o_cmd[1]), .addr_o(o_addr[1]), .addr_cnt_o(o_cnt[1]), .col_off_o(o_off[1]),
    .act_load_o(o_act[1][5]), .act_setup_o(o_act[1][4]), .act_prog_o(o_act[1][3]),
    .act_erase_o(o_act[1][2]), .act_id_o(o_act[1][1]), .act_status_o(o_act[1][0]),
    .bad_cmd_o(o_bad[1]));

  nand_cmd_seq #(.LARGE_PAGE(1'b0), .DEV_MBIT(128), .PAGE_BYTES(512)) u_nand_cmd_seq_sp (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_i(we), .cle_i(cle), .ale_i(ale), .io_i(io),
    .cmd_o(o_cmd[2]), .addr_o(o_addr[2]), .addr_cnt_o(o_cnt[2]), .col_off_o(o_off[2]),
    .act_load_o(o_act[2][5]), .act_setup_o(o_act[2][4]), .act_prog_o(o_act[2][3]),
    .act_erase_o(o_act[2][2]), .act_id_o(o_act[2][1]), .act_status_o(o_act[2][0]),
    .bad_cmd_o(o_bad[2]));

  // behavioural reference, one slot per configuration
  bit          lg   [3] = '{1'b1, 1'b1, 1'b0};
  int          trig [3] = '{5, 4, 3};
  int          pgb  [3] = '{2048, 2048, 512};
  int          m_cmd  [3];
  logic [39:0] m_addr [3];
  int          m_cnt  [3];
  int          m_off  [3];
  bit    [5:0] m_act  [3];
  bit          m_bad  [3];

  function automatic bit is_known(int b);
    return b inside {8'h00, 8'h01, 8'h50, 8'h30, 8'h05, 8'hE0, 8'h35, 8'h90,
                     8'hFF, 8'h80, 8'h10, 8'h60, 8'hD0, 8'h70, 8'h85};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n) begin
        m_cmd[k] = 0; m_addr[k] = '0; m_cnt[k] = 0; m_off[k] = 0; m_act[k] = '0; m_bad[k] = 0;
      end else begin
        bit [5:0] a;
        int b;
        a = '0;
        b = int'(io);
        if (we && !ce_n && cle) begin
          if (lg[k] && m_cmd[k] == 0 && b == 8'h30) begin
          end else if (lg[k] && b == 8'h05) begin
            m_addr[k][15:0] = '0;
            m_cnt[k] = 0;
          end else begin
            if (!is_known(b)) m_bad[k] = 1;
            if (b == 8'hFF) begin
              m_cmd[k] = 0; m_addr[k] = '0; m_off[k] = 0;
            end else begin
              if (b == 8'h00) m_off[k] = 0;
              if (b == 8'h01) m_off[k] = 256;
              if (b == 8'h50) m_off[k] = pgb[k];
              m_cmd[k] = (b == 8'h01 || b == 8'h50) ? 0 : b;
            end
            if (b == 8'h70) a[0] = 1;
            if (b == 8'h10) a[3] = 1;
            if (b == 8'hD0) begin
              a[2] = 1;
              m_addr[k] = m_addr[k] << (lg[k] ? 16 : 8);
            end
            if (lg[k] && (b == 8'hE0 || b == 8'h35)) a[5] = 1;
            if (b != 8'hE0) m_cnt[k] = 0;
          end
        end else if (we && !ce_n && ale) begin
          if (m_cnt[k] < 5) m_addr[k][8*m_cnt[k] +: 8] = io;
          if (m_cmd[k] == 8'h90 && m_cnt[k] == 0) a[1] = 1;
          if (m_cnt[k] == trig[k] - 1 && m_cmd[k] == 8'h00) a[5] = 1;
          if (m_cnt[k] == trig[k] - 1 && m_cmd[k] == 8'h80) a[4] = 1;
          if (m_cnt[k] < 7) m_cnt[k]++;
        end
        m_act[k] = a;
      end
    end
  end

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 3; k++) begin
        chk($sformatf("R2 cmd cfg%0d", k), o_cmd[k], m_cmd[k]);
        chk($sformatf("R4 addr cfg%0d", k), o_addr[k], m_addr[k]);
        chk($sformatf("R5 cnt cfg%0d", k), o_cnt[k], m_cnt[k]);
        chk($sformatf("R3 off cfg%0d", k), o_off[k], m_off[k]);
        chk($sformatf("R6 act_id_load_setup cfg%0d", k), {o_act[k][5:4], o_act[k][1]}, {m_act[k][5:4], m_act[k][1]});
        chk($sformatf("R7 act_imm cfg%0d", k), {o_act[k][3:2], o_act[k][0]}, {m_act[k][3:2], m_act[k][0]});
        chk($sformatf("R11 bad cfg%0d", k), o_bad[k], m_bad[k]);
      end
    end
  end

  task automatic strobe(bit c, bit a, bit cen, logic [7:0] d);
    @(negedge clk);
    ce_n = cen; cle = c; ale = a; io = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask
  task automatic wcmd(logic [7:0] d); strobe(1, 0, 0, d); endtask
  task automatic wadr(logic [7:0] d); strobe(0, 1, 0, d); endtask

  task automatic reset_state_check;
    for (int k = 0; k < 3; k++) begin
      chk("R1 cmd", o_cmd[k], 0);
      chk("R1 addr", o_addr[k], 0);
      chk("R1 cnt", o_cnt[k], 0);
      chk("R1 off", o_off[k], 0);
      chk("R1 act", o_act[k], 0);
      chk("R1 bad", o_bad[k], 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [7:0] OPS [16] = '{8'h00, 8'h01, 8'h50, 8'h30, 8'h05, 8'hE0, 8'h35, 8'h90,
                                      8'hFF, 8'h80, 8'h10, 8'h60, 8'hD0, 8'h70, 8'h85, 8'h42};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_state_check();

    // read with five address bytes: triggers at 3, 4, 5
    wcmd(8'h00);
    wadr(8'h11); wadr(8'h22); wadr(8'h33); wadr(8'h44); wadr(8'h55);
    chk("R4 le addr", o_addr[0], 40'h5544332211);
    // large-page confirm ignored, random column
    wcmd(8'h30);
    chk("R10 skip keeps cnt", o_cnt[0], 5);
    chk("R10 small stores 30", o_cmd[2], 8'h30);
    wcmd(8'h00);
    wcmd(8'h05); wadr(8'h34); wadr(8'h12);
    wcmd(8'hE0);
    chk("R5 E0 keeps cnt", o_cnt[0], 2);
    wcmd(8'h35);
    // offset variants
    wcmd(8'h01);
    chk("R3 half offset", o_off[0], 16'h100);
    chk("R2 01 stored as 00", o_cmd[0], 0);
    wcmd(8'h50);
    chk("R3 page offset lp", o_off[0], 2048);
    chk("R3 page offset sp", o_off[2], 512);
    // identifier, status, program
    wcmd(8'h90); wadr(8'h00);
    wcmd(8'h70);
    wcmd(8'h80);
    for (int i = 0; i < 5; i++) wadr(8'(8'hA0 + i));
    strobe(0, 0, 0, 8'h5A); strobe(0, 0, 0, 8'hA5);
    wcmd(8'h10);
    // reset command then erase
    wcmd(8'hFF);
    chk("R9 reset cmd", o_cmd[0], 0);
    chk("R9 reset addr", o_addr[0], 0);
    wcmd(8'h60); wadr(8'hAA); wadr(8'hBB); wadr(8'hCC);
    wcmd(8'hD0);
    chk("R8 erase shift lp", o_addr[0], 40'hCCBBAA0000);
    chk("R8 erase shift sp", o_addr[2], 40'h00CCBBAA00);
    // overflow of address slots
    wcmd(8'h00);
    for (int i = 0; i < 9; i++) wadr(8'(8'h10 + i));
    chk("R5 cnt saturates", o_cnt[0], 7);
    chk("R4 extra bytes dropped", o_addr[0], 40'h1413121110);
    // unknown opcode
    wcmd(8'h42);
    chk("R11 unknown flag", o_bad[0], 1);
    // chip disabled
    strobe(1, 0, 1, 8'h70);
    chk("R12 ce high ignored", o_cmd[0], 8'h42);
    chk("R12 ce high no pulse", o_act[0], 0);
    // cle wins over ale
    strobe(1, 1, 0, 8'h70);
    chk("R12 cle priority", o_cmd[0], 8'h70);
    // mixed stimulus
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) wcmd((r == 0) ? 8'($urandom) : OPS[$urandom_range(0, 15)]);
      else if (r < 8) wadr(8'($urandom));
      else strobe($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, 8'($urandom));
    end
    // mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_state_check();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule